// File: doc/BRIEF.md
# Host–Coprocessor Mailbox with Reset Detector

This block joins a host bus to an on-board coprocessor through four byte-wide mailbox slots. The host posts commands and data bytes toward the coprocessor. The coprocessor posts status and data bytes back toward the host. Five handshake flags, gathered in one coprocessor-readable byte, tell each side when a slot holds fresh content or may be reused. There is no overwrite protection: a writer checks the matching flag before writing.

The coprocessor can interrupt the host. It first enables host interrupts in its control byte, then writes a vector byte. The request stays up until the host acknowledges it. During the acknowledge, the vector appears on the host read bus.

All host command writes pass through a six-byte pattern matcher. When the pattern completes and a configuration input permits it, the block emits a multi-cycle reset pulse to the coprocessor. That pulse also returns the flags and the interrupt control to their reset state.

Top module: `host_mailbox`

## Requirements
- R1: A host write with `hostSel`=0 stores the command byte, sets command-available (flags bit 0) and clears command-empty (flags bit 1). A coprocessor read at address 0 returns the byte and clears command-available.
- R2: Command-empty is set only by a coprocessor write to address 5 with data bit 1 high, or by a reset. A coprocessor command read leaves it clear.
- R3: A host write with `hostSel`=1 stores the data byte and sets data-available (flags bit 2). A coprocessor read at address 1 returns the byte and clears that flag.
- R4: A coprocessor write at address 2 stores the outgoing data byte and clears out-data-empty (flags bit 3). A host read with `hostSel`=1 returns the byte and sets the flag.
- R5: A coprocessor write at address 3 stores the status byte and clears status-empty (flags bit 4). A host read with `hostSel`=0 returns the byte and sets the flag.
- R6: After `rst_n` the following hold: the flags byte, read at coprocessor address 4, is 8'h1A; the control byte at address 5 is 0; `hostIrq` and `copReset` are low.
- R7: A second write to a slot that was not read replaces the earlier byte.
- R8: The command bytes 7E, 55, 0F, 70, 2A, 7E written back to back with `resetSeqEnable` high make `copReset` rise on the clock edge that takes the last byte. It stays high for `RST_CYCLES` cycles.
- R9: With `resetSeqEnable` low, the same pattern produces no `copReset`.
- R10: A command byte that breaks the pattern restarts matching. If that byte is 7E, it counts as the first byte of a new pattern.
- R11: While `copReset` is high, the flags return to 8'h1A, the interrupt enable (control bit 0) clears, and any pending host request is dropped.
- R12: A coprocessor write at address 6 while control bit 0 is set raises `hostIrq` and latches the vector. With bit 0 clear, the write has no effect.
- R13: While `hostIrqAck` is high and a request is pending, `hostRdData` shows the vector. The request is cleared on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostSel | input | 1 | 0: command/status slot, 1: data slot |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte (vector during acknowledge) |
| hostIrq | output | 1 | Host interrupt request |
| hostIrqAck | input | 1 | Host interrupt acknowledge |
| copWrEn | input | 1 | Coprocessor write strobe |
| copRdEn | input | 1 | Coprocessor read strobe |
| copAddr | input | 3 | Coprocessor register select |
| copWrData | input | 8 | Coprocessor write byte |
| copRdData | output | 8 | Coprocessor read byte |
| resetSeqEnable | input | 1 | Allows the command pattern to reset the coprocessor |
| copReset | output | 1 | Registered coprocessor reset pulse |

## Verification
The assertions assume the following:
- Each strobe is a single-cycle, one-access-per-side pulse.
- `hostIrqAck` comes only while a request is pending.
- No slot is written on the same edge that reads it from the other side.

The stimulus keeps to these rules. Every access is issued from a task that raises a strobe for exactly one cycle. Accesses from the two sides never share a cycle. The acknowledge is raised only after `hostIrq` has been seen high.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef struct packed {
    logic hostCmdWr;
    logic hostDataWr;
    logic hostStatRd;
    logic hostDataRd;
    logic copCmdRd;
    logic copDataRd;
    logic copDataWr;
    logic copStatWr;
    logic copSetCmdEmpty;
    logic clearAll;
  } mbox_strobe_t;

  localparam logic [2:0] COP_CMD   = 3'd0;
  localparam logic [2:0] COP_DFH   = 3'd1;
  localparam logic [2:0] COP_DTH   = 3'd2;
  localparam logic [2:0] COP_STAT  = 3'd3;
  localparam logic [2:0] COP_FLAGS = 3'd4;
  localparam logic [2:0] COP_CTRL  = 3'd5;
  localparam logic [2:0] COP_VEC   = 3'd6;

  localparam int SEQ_LEN = 6;
  localparam logic [4:0] FLAGS_RESET = 5'b11010;

  function automatic logic [7:0] seqByte(input logic [2:0] idx);
    case (idx)
      3'd0: seqByte = 8'h7E;
      3'd1: seqByte = 8'h55;
      3'd2: seqByte = 8'h0F;
      3'd3: seqByte = 8'h70;
      3'd4: seqByte = 8'h2A;
      3'd5: seqByte = 8'h7E;
      default: seqByte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hostWrEn,
  input  logic         hostRdEn,
  input  logic         hostSel,
  input  logic [7:0]   hostWrData,
  input  logic         hostIrqAck,
  input  logic         copWrEn,
  input  logic         copRdEn,
  input  logic [2:0]   copAddr,
  input  logic [7:0]   copWrData,
  input  logic         resetSeqEnable,
  output mbox_strobe_t strb,
  output logic         copReset,
  output logic         irqEn,
  output logic         irqPend,
  output logic [7:0]   vecReg
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);
  localparam logic [2:0] LAST_IDX = 3'(SEQ_LEN - 1);

  logic [2:0]       seqIdx;
  logic [CNT_W-1:0] rstCnt;
  logic             seqHit, seqDone, ackNow, vecWr;

  assign ackNow = hostIrqAck && irqPend;
  assign vecWr  = copWrEn && (copAddr == COP_VEC);

  always_comb begin
    strb.hostCmdWr      = hostWrEn && !hostSel;
    strb.hostDataWr     = hostWrEn && hostSel;
    strb.hostStatRd     = hostRdEn && !hostSel && !ackNow;
    strb.hostDataRd     = hostRdEn && hostSel && !ackNow;
    strb.copCmdRd       = copRdEn && (copAddr == COP_CMD);
    strb.copDataRd      = copRdEn && (copAddr == COP_DFH);
    strb.copDataWr      = copWrEn && (copAddr == COP_DTH);
    strb.copStatWr      = copWrEn && (copAddr == COP_STAT);
    strb.copSetCmdEmpty = copWrEn && (copAddr == COP_CTRL) && copWrData[1];
    strb.clearAll       = copReset;
  end

  assign seqHit  = strb.hostCmdWr && (hostWrData == seqByte(seqIdx));
  assign seqDone = seqHit && (seqIdx == LAST_IDX);

  // pattern matcher
  always_ff @(posedge clk) begin
    if (!rst_n || copReset) begin
      seqIdx <= 3'd0;
    end else if (strb.hostCmdWr) begin
      if (seqDone)     seqIdx <= 3'd0;
      else if (seqHit) seqIdx <= seqIdx + 3'd1;
      else             seqIdx <= (hostWrData == seqByte(3'd0)) ? 3'd1 : 3'd0;
    end
  end

  // reset pulse generator
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rstCnt   <= '0;
      copReset <= 1'b0;
    end else if (seqDone && resetSeqEnable && !copReset) begin
      rstCnt   <= CNT_LOAD;
      copReset <= 1'b1;
    end else if (rstCnt != '0) begin
      rstCnt   <= rstCnt - 1'b1;
    end else begin
      copReset <= 1'b0;
    end
  end

  // interrupt control
  always_ff @(posedge clk) begin
    if (!rst_n || copReset) begin
      irqEn   <= 1'b0;
      irqPend <= 1'b0;
      vecReg  <= 8'h00;
    end else begin
      if (copWrEn && (copAddr == COP_CTRL)) irqEn <= copWrData[0];
      if (vecWr && irqEn) begin
        irqPend <= 1'b1;
        vecReg  <= copWrData;
      end else if (ackNow) begin
        irqPend <= 1'b0;
      end
    end
  end

  // R8
  rst_after_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(copReset) |-> $past(hostWrEn && !hostSel && hostWrData == 8'h7E));
  // R9
  rst_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(copReset) |-> $past(resetSeqEnable));
  // R12
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqPend) |-> $past(irqEn && copWrEn));
  // R13
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hostIrqAck && irqPend && !vecWr) |=> !irqPend);

endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  mbox_strobe_t strb,
  input  logic         hostSel,
  input  logic [7:0]   hostWrData,
  input  logic         hostIrqAck,
  input  logic [2:0]   copAddr,
  input  logic [7:0]   copWrData,
  input  logic         irqEn,
  input  logic         irqPend,
  input  logic [7:0]   vecReg,
  output logic [7:0]   hostRdData,
  output logic [7:0]   copRdData
);

  logic [7:0] cmdByte, dfhByte, dthByte, statByte;
  logic       cmdAvail, cmdEmpty, dfhAvail, dthEmpty, statEmpty;
  logic [4:0] flags;

  assign flags = {statEmpty, dthEmpty, dfhAvail, cmdEmpty, cmdAvail};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdByte  <= 8'h00;
      dfhByte  <= 8'h00;
      dthByte  <= 8'h00;
      statByte <= 8'h00;
    end else begin
      if (strb.hostCmdWr)  cmdByte  <= hostWrData;
      if (strb.hostDataWr) dfhByte  <= hostWrData;
      if (strb.copDataWr)  dthByte  <= copWrData;
      if (strb.copStatWr)  statByte <= copWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clearAll) begin
      {statEmpty, dthEmpty, dfhAvail, cmdEmpty, cmdAvail} <= FLAGS_RESET;
    end else begin
      if (strb.hostCmdWr)           cmdAvail <= 1'b1;
      else if (strb.copCmdRd)       cmdAvail <= 1'b0;
      if (strb.hostCmdWr)           cmdEmpty <= 1'b0;
      else if (strb.copSetCmdEmpty) cmdEmpty <= 1'b1;
      if (strb.hostDataWr)          dfhAvail <= 1'b1;
      else if (strb.copDataRd)      dfhAvail <= 1'b0;
      if (strb.copDataWr)           dthEmpty <= 1'b0;
      else if (strb.hostDataRd)     dthEmpty <= 1'b1;
      if (strb.copStatWr)           statEmpty <= 1'b0;
      else if (strb.hostStatRd)     statEmpty <= 1'b1;
    end
  end

  always_comb begin
    if (hostIrqAck && irqPend) hostRdData = vecReg;
    else if (hostSel)          hostRdData = dthByte;
    else                       hostRdData = statByte;
  end

  always_comb begin
    case (copAddr)
      COP_CMD:   copRdData = cmdByte;
      COP_DFH:   copRdData = dfhByte;
      COP_FLAGS: copRdData = {3'b000, flags};
      COP_CTRL:  copRdData = {7'b0, irqEn};
      default:   copRdData = 8'h00;
    endcase
  end

  // R11
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAll |=> (flags == FLAGS_RESET));
  // R2
  cmd_empty_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmdEmpty) |-> $past(strb.copSetCmdEmpty || strb.clearAll));
  // R3
  dfh_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dfhAvail) |-> $past(strb.copDataRd || strb.clearAll));
  // R1
  cmd_avail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmdAvail) |-> $past(strb.hostCmdWr));

endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import mbox_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  input  logic       hostSel,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  output logic       hostIrq,
  input  logic       hostIrqAck,
  input  logic       copWrEn,
  input  logic       copRdEn,
  input  logic [2:0] copAddr,
  input  logic [7:0] copWrData,
  output logic [7:0] copRdData,
  input  logic       resetSeqEnable,
  output logic       copReset
);

  mbox_strobe_t strb;
  logic         irqEn, irqPend;
  logic [7:0]   vecReg;

  mbox_ctrl #(.RST_CYCLES(RST_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostIrqAck(hostIrqAck),
    .copWrEn(copWrEn), .copRdEn(copRdEn), .copAddr(copAddr),
    .copWrData(copWrData), .resetSeqEnable(resetSeqEnable),
    .strb(strb), .copReset(copReset), .irqEn(irqEn),
    .irqPend(irqPend), .vecReg(vecReg)
  );

  mbox_dp dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostIrqAck(hostIrqAck),
    .copAddr(copAddr), .copWrData(copWrData), .irqEn(irqEn),
    .irqPend(irqPend), .vecReg(vecReg),
    .hostRdData(hostRdData), .copRdData(copRdData)
  );

  assign hostIrq = irqPend;

endmodule

// File: tb/host_mailbox_tb_top.sv
module host_mailbox_tb_top;

  localparam int PULSE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hostWrEn = 0, hostRdEn = 0, hostSel = 0, hostIrqAck = 0;
  logic [7:0] hostWrData = 0, copWrData = 0;
  logic       copWrEn = 0, copRdEn = 0, resetSeqEnable = 0;
  logic [2:0] copAddr = 0;
  logic [7:0] hostRdData, copRdData;
  logic       hostIrq, copReset;

  int checks = 0;
  int errors = 0;
  logic resetSeen = 0;

  always #10 clk = ~clk;

  host_mailbox #(.RST_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostSel(hostSel), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .hostIrq(hostIrq), .hostIrqAck(hostIrqAck), .copWrEn(copWrEn),
    .copRdEn(copRdEn), .copAddr(copAddr), .copWrData(copWrData),
    .copRdData(copRdData), .resetSeqEnable(resetSeqEnable), .copReset(copReset)
  );

  always @(negedge clk) if (copReset) resetSeen <= 1'b1;

  function automatic logic [7:0] patByte(input int i);
    case (i)
      0: patByte = 8'h7E; 1: patByte = 8'h55; 2: patByte = 8'h0F;
      3: patByte = 8'h70; 4: patByte = 8'h2A; default: patByte = 8'h7E;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [7:0] d);
    @(negedge clk); hostWrEn = 1; hostSel = sel; hostWrData = d;
    @(negedge clk); hostWrEn = 0;
  endtask

  task automatic hostRead(input logic sel, output logic [7:0] d);
    @(negedge clk); hostRdEn = 1; hostSel = sel; #1 d = hostRdData;
    @(negedge clk); hostRdEn = 0;
  endtask

  task automatic copWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); copWrEn = 1; copAddr = a; copWrData = d;
    @(negedge clk); copWrEn = 0;
  endtask

  task automatic copRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); copRdEn = 1; copAddr = a; #1 d = copRdData;
    @(negedge clk); copRdEn = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); copAddr = a; #1 d = copRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] r;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R6 reset state
    peek(3'd4, r); chk("R6 flags", r, 8'h1A);
    peek(3'd5, r); chk("R6 ctrl", r, 8'h00);
    chk("R6 irq", {7'b0, hostIrq}, 8'h00);
    chk("R6 copReset", {7'b0, copReset}, 8'h00);

    // R3 sweep of data-from-host
    for (int v = 0; v < 256; v++) begin
      hostWrite(1'b1, 8'(v));
      peek(3'd4, r); chk("R3 avail set", {7'b0, r[2]}, 8'h01);
      copRead(3'd1, r); chk("R3 data", r, 8'(v));
      peek(3'd4, r); chk("R3 avail clr", {7'b0, r[2]}, 8'h00);
    end

    // R7 overwrite
    hostWrite(1'b1, 8'hAA); hostWrite(1'b1, 8'h5A);
    copRead(3'd1, r); chk("R7 replace", r, 8'h5A);
    copWrite(3'd2, 8'h11); copWrite(3'd2, 8'h22);
    hostRead(1'b1, r); chk("R7 replace out", r, 8'h22);

    // R4 sweep of data-to-host
    for (int v = 0; v < 256; v += 3) begin
      copWrite(3'd2, 8'(255 - v));
      peek(3'd4, r); chk("R4 empty clr", {7'b0, r[3]}, 8'h00);
      hostRead(1'b1, r); chk("R4 data", r, 8'(255 - v));
      peek(3'd4, r); chk("R4 empty set", {7'b0, r[3]}, 8'h01);
    end

    // R5 status slot
    for (int v = 1; v < 256; v += 17) begin
      copWrite(3'd3, 8'(v));
      peek(3'd4, r); chk("R5 empty clr", {7'b0, r[4]}, 8'h00);
      hostRead(1'b0, r); chk("R5 status", r, 8'(v));
      peek(3'd4, r); chk("R5 empty set", {7'b0, r[4]}, 8'h01);
    end

    // R1 / R2 command slot
    for (int v = 0; v < 256; v += 5) begin
      hostWrite(1'b0, 8'(v));
      peek(3'd4, r); chk("R1 avail/empty", {6'b0, r[1:0]}, 8'h01);
      copRead(3'd0, r); chk("R1 cmd", r, 8'(v));
      peek(3'd4, r); chk("R2 no auto empty", {6'b0, r[1:0]}, 8'h00);
      copWrite(3'd5, 8'h02);
      peek(3'd4, r); chk("R2 set by ctrl", {6'b0, r[1:0]}, 8'h02);
    end
    chk("R9 no reset during sweep", {7'b0, resetSeen}, 8'h00);

    // R12 / R13 interrupt
    copWrite(3'd5, 8'h00);
    copWrite(3'd6, 8'hF4); idle(1);
    chk("R12 ignored", {7'b0, hostIrq}, 8'h00);
    copWrite(3'd5, 8'h01);
    copWrite(3'd6, 8'hFA); idle(1);
    chk("R12 raised", {7'b0, hostIrq}, 8'h01);
    @(negedge clk); hostIrqAck = 1; #1 chk("R13 vector", hostRdData, 8'hFA);
    @(negedge clk); hostIrqAck = 0;
    chk("R13 cleared", {7'b0, hostIrq}, 8'h00);

    // R8 / R11 reset sequence
    copWrite(3'd6, 8'hFC); hostWrite(1'b1, 8'h33); copWrite(3'd3, 8'h44);
    resetSeqEnable = 1;
    for (int i = 0; i < 6; i++) hostWrite(1'b0, patByte(i));
    chk("R8 pulse start", {7'b0, copReset}, 8'h01);
    cnt = 0;
    while (copReset && cnt < 100) begin cnt++; @(negedge clk); end
    chk("R8 pulse length", 8'(cnt), 8'(PULSE));
    peek(3'd4, r); chk("R11 flags", r, 8'h1A);
    peek(3'd5, r); chk("R11 ctrl", r, 8'h00);
    chk("R11 irq dropped", {7'b0, hostIrq}, 8'h00);

    // R9 disabled
    resetSeqEnable = 0; resetSeen = 0;
    for (int i = 0; i < 6; i++) hostWrite(1'b0, patByte(i));
    idle(8);
    chk("R9 no pulse", {7'b0, resetSeen}, 8'h00);
    peek(3'd4, r); chk("R9 flags kept", r, 8'h19);

    // R10 break and restart
    resetSeqEnable = 1;
    for (int k = 1; k <= 4; k++) begin
      resetSeen = 0;
      for (int i = 0; i < k; i++) hostWrite(1'b0, patByte(i));
      hostWrite(1'b0, 8'h7E);
      for (int i = 1; i < 6; i++) hostWrite(1'b0, patByte(i));
      idle(8);
      chk("R10 7E restarts", {7'b0, resetSeen}, 8'h01);
      resetSeen = 0;
      for (int i = 0; i < k; i++) hostWrite(1'b0, patByte(i));
      hostWrite(1'b0, 8'h00);
      for (int i = 1; i < 6; i++) hostWrite(1'b0, patByte(i));
      idle(8);
      chk("R10 break aborts", {7'b0, resetSeen}, 8'h00);
    end

    finishRun();
  end

endmodule